// File: doc/BRIEF.md
# Endpoint Ping-Pong Packet Buffer

This block holds the packet storage of one configurable USB device endpoint and arbitrates it between the serial interface engine (SIE) and a CPU or DMA port. A static configuration picks the transfer direction, the buffer size in 64-byte steps, single or double buffering, the max packet size and an optional trailing zero-length packet. With double buffering the storage is split into two equal halves. One half belongs to the SIE and the other to the CPU. Neither side can reach the half it does not own.

For an OUT endpoint the SIE fills its half and signals the end of the packet. For an IN endpoint the CPU fills its half and commits it. The halves trade places only once the filling side has finished and the draining side has emptied its half. In single-buffer mode the one buffer is handed back and forth under the same rule. The filling side is locked out while the draining side holds the buffer. The CPU side reports the byte count, a short-packet flag and a ready indication. The SIE side reports whether a packet is waiting to be sent and whether a zero-length packet is owed.

Top module: `epbuf_pingpong`

## Requirements
- R1: The buffer limit is (cfg_size + 1) * 64 bytes, capped at 1024. Bytes that the filling side writes beyond the limit are dropped, and the count stops at the limit.
- R2: OUT direction: bytes the SIE writes are handed to the CPU once sie_rx_done has been seen. cpu_ready then goes to 1 and cpu_len shows the count. Each cpu_rd_en returns the next byte in arrival order on cpu_rd_data in the following cycle.
- R3: OUT with double buffering: the SIE may fill the second half while the CPU holds the first. The new packet reaches the CPU only after the SIE has finished it and the CPU has read every byte of the previous one.
- R4: Single buffering: while the draining side holds the buffer, writes and finish strobes from the filling side are ignored, and sie_rx_ok (OUT) or cpu_ready (IN) is 0.
- R5: IN direction: after cpu_commit, sie_tx_avail goes to 1 and sie_tx_len shows the count. Each sie_rd_en returns the next committed byte in order on sie_rd_data in the following cycle.
- R6: IN with double buffering: the CPU may fill and commit the second half while the SIE holds the first. That packet is offered to the SIE only after a sie_tx_done for the first.
- R7: IN with cfg_zlp_en = 1: a committed packet whose length is a nonzero multiple of cfg_mps leaves sie_tx_zlp = 1 and sie_tx_avail = 0 after its sie_tx_done. The next sie_tx_done clears sie_tx_zlp, and no further packet is offered before then. With cfg_zlp_en = 0, sie_tx_zlp stays 0.
- R8: OUT: cpu_short is 1 when the packet handed to the CPU has fewer than cfg_mps bytes, and 0 otherwise.
- R9: cfg_bad is 1, one cycle after the configuration is applied, exactly when the direction is IN and either double buffering has a limit ≤ cfg_mps, or single buffering has a limit < cfg_mps.
- R10: Reads beyond the byte count of the held packet are ignored, and the read data keeps its last value.
- R11: After reset: no packet is held, sie_tx_avail = 0, sie_tx_zlp = 0, cpu_len = 0. OUT shows sie_rx_ok = 1 and cpu_ready = 0. IN shows cpu_ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_dbl | input | 1 | 1 = two halves, 0 = one shared buffer |
| cfg_size | input | 4 | Buffer size code, (code+1)*64 bytes |
| cfg_mps | input | 11 | Max packet size in bytes (at least 1) |
| cfg_zlp_en | input | 1 | Append a zero-length packet after exact-multiple IN packets |
| sie_wr_en | input | 1 | SIE byte write strobe (OUT) |
| sie_wr_data | input | 8 | SIE byte to store |
| sie_rx_done | input | 1 | SIE finished receiving a packet |
| sie_rx_ok | output | 1 | SIE may write a packet now (OUT) |
| sie_rd_en | input | 1 | SIE byte read strobe (IN) |
| sie_rd_data | output | 8 | Byte read by the SIE, one cycle after the strobe |
| sie_tx_done | input | 1 | SIE finished transmitting the offered packet |
| sie_tx_avail | output | 1 | A committed IN packet is waiting for the SIE |
| sie_tx_len | output | 11 | Byte count of the offered IN packet |
| sie_tx_zlp | output | 1 | A zero-length packet is owed next |
| cpu_wr_en | input | 1 | CPU byte write strobe (IN) |
| cpu_wr_data | input | 8 | CPU byte to store |
| cpu_commit | input | 1 | CPU finished filling an IN packet |
| cpu_rd_en | input | 1 | CPU byte read strobe (OUT) |
| cpu_rd_data | output | 8 | Byte read by the CPU, one cycle after the strobe |
| cpu_ready | output | 1 | CPU holds unread OUT data, or an empty IN half |
| cpu_len | output | 11 | Bytes in the CPU-side half |
| cpu_short | output | 1 | The OUT packet held by the CPU is shorter than cfg_mps |
| cfg_bad | output | 1 | The IN size versus max-packet setting is illegal |

## Verification
A wrong ownership or swap state shows at the ports within two cycles of the triggering strobe. A second OUT packet that overwrote the first would show up as changed bytes in the CPU read stream. A swap taken too early would change cpu_len or sie_tx_len before the draining side had finished. A lost zero-length flag would offer the next IN packet one sie_tx_done too soon. The bench therefore checks the counts and flags after every finish strobe, reads every packet back byte by byte, and issues strobes that must be ignored. The state those strobes could have disturbed is then read through the normal port.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic {DIR_OUT = 1'b0, DIR_IN = 1'b1} ep_dir_e;
endpackage

// File: rtl/epbuf_cfg.sv
module epbuf_cfg #(
  parameter int MAX_BYTES  = 1024,
  parameter int UNIT_BYTES = 64,
  parameter int SIZE_W     = 4,
  parameter int CNT_W      = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_in,
  input  logic              dbl,
  input  logic [SIZE_W-1:0] size,
  input  logic [CNT_W-1:0]  mps,
  output logic [CNT_W-1:0]  lim,
  output logic              cfg_bad
);
  int raw_bytes;

  always_comb begin
    raw_bytes = (int'(size) + 1) * UNIT_BYTES;
    if (raw_bytes > MAX_BYTES) lim = CNT_W'(MAX_BYTES);
    else                       lim = CNT_W'(raw_bytes);
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_bad <= 1'b0;
    else     cfg_bad <= dir_in && (dbl ? (lim <= mps) : (lim < mps));
  end
endmodule

// File: rtl/epbuf_ram.sv
module epbuf_ram #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/epbuf_own.sv
module epbuf_own #(
  parameter int PTR_W = 10,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dbl,
  input  logic             dir_in,
  input  logic             zlp_en,
  input  logic [CNT_W-1:0] lim,
  input  logic [CNT_W-1:0] mps,
  input  logic             w_en,
  input  logic             w_fin_in,
  input  logic             r_en,
  input  logic             r_done_in,
  output logic             we,
  output logic [PTR_W:0]   waddr,
  output logic             re,
  output logic [PTR_W:0]   raddr,
  output logic             w_open,
  output logic [CNT_W-1:0] w_cnt_o,
  output logic             r_busy_o,
  output logic             r_left_o,
  output logic [CNT_W-1:0] r_cnt_o,
  output logic             r_short_o,
  output logic             zlp_pend_o
);
  logic             w_h, w_fin, r_busy, r_short, r_zlp, zlp_pend;
  logic [CNT_W-1:0] w_cnt, w_mod, r_cnt, r_ptr, w_mod_nx;
  logic             r_h, w_take, fin_take, r_take, swap;
  logic             out_drained, tx_end, zlp_end;

  always_comb begin
    r_h         = dbl ? ~w_h : w_h;
    w_open      = !w_fin && (dbl || !r_busy);
    w_take      = w_en && w_open && (w_cnt < lim);
    fin_take    = w_fin_in && w_open;
    r_take      = r_en && r_busy && (r_ptr < r_cnt);
    swap        = w_fin && !r_busy && !zlp_pend;
    out_drained = !dir_in && r_busy && (r_ptr == r_cnt);
    tx_end      = dir_in && r_done_in && r_busy;
    zlp_end     = dir_in && r_done_in && !r_busy && zlp_pend;
    w_mod_nx    = (w_mod + CNT_W'(1) == mps) ? '0 : w_mod + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_h <= 1'b0; w_fin <= 1'b0; w_cnt <= '0; w_mod <= '0;
      r_busy <= 1'b0; r_cnt <= '0; r_ptr <= '0;
      r_short <= 1'b0; r_zlp <= 1'b0; zlp_pend <= 1'b0;
    end else begin
      if (w_take) begin
        w_cnt <= w_cnt + CNT_W'(1);
        w_mod <= w_mod_nx;
      end
      if (fin_take) w_fin <= 1'b1;
      if (swap) begin
        w_fin   <= 1'b0;
        w_cnt   <= '0;
        w_mod   <= '0;
        w_h     <= dbl ? ~w_h : w_h;
        r_busy  <= 1'b1;
        r_cnt   <= w_cnt;
        r_ptr   <= '0;
        r_short <= (w_cnt < mps);
        r_zlp   <= zlp_en && dir_in && (w_cnt != '0) && (w_mod == '0);
      end else if (out_drained) begin
        r_busy <= 1'b0;
      end else if (tx_end) begin
        r_busy   <= 1'b0;
        zlp_pend <= r_zlp;
      end
      if (zlp_end) zlp_pend <= 1'b0;
      if (r_take)  r_ptr <= r_ptr + CNT_W'(1);
    end
  end

  assign we         = w_take;
  assign waddr      = {w_h, w_cnt[PTR_W-1:0]};
  assign re         = r_take;
  assign raddr      = {r_h, r_ptr[PTR_W-1:0]};
  assign w_cnt_o    = w_cnt;
  assign r_busy_o   = r_busy;
  assign r_left_o   = r_busy && (r_ptr != r_cnt);
  assign r_cnt_o    = r_cnt;
  assign r_short_o  = r_short;
  assign zlp_pend_o = zlp_pend;

  // R1
  lim_cap_chk: assert property (@(posedge clk) disable iff (rst)
    w_cnt <= lim);

  // R3 R6
  swap_fin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(r_busy) |-> $past(w_fin));

  // R4
  single_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!dbl && $past(r_busy) && r_busy) |-> $stable(w_cnt));

  // R7
  zlp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    zlp_pend |-> !r_busy);

  // R10
  rptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    r_ptr <= r_cnt);
endmodule

// File: rtl/epbuf_pingpong.sv
module epbuf_pingpong
  import epbuf_pkg::*;
#(
  parameter int MAX_BYTES  = 1024,
  parameter int UNIT_BYTES = 64,
  parameter int SIZE_W     = 4,
  localparam int PTR_W     = $clog2(MAX_BYTES),
  localparam int CNT_W     = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_dir_in,
  input  logic              cfg_dbl,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [CNT_W-1:0]  cfg_mps,
  input  logic              cfg_zlp_en,
  input  logic              sie_wr_en,
  input  logic [7:0]        sie_wr_data,
  input  logic              sie_rx_done,
  output logic              sie_rx_ok,
  input  logic              sie_rd_en,
  output logic [7:0]        sie_rd_data,
  input  logic              sie_tx_done,
  output logic              sie_tx_avail,
  output logic [CNT_W-1:0]  sie_tx_len,
  output logic              sie_tx_zlp,
  input  logic              cpu_wr_en,
  input  logic [7:0]        cpu_wr_data,
  input  logic              cpu_commit,
  input  logic              cpu_rd_en,
  output logic [7:0]        cpu_rd_data,
  output logic              cpu_ready,
  output logic [CNT_W-1:0]  cpu_len,
  output logic              cpu_short,
  output logic              cfg_bad
);
  localparam int AW    = PTR_W + 1;
  localparam int DEPTH = 2 * MAX_BYTES;

  ep_dir_e          dir;
  logic [CNT_W-1:0] lim, w_cnt, r_cnt;
  logic             w_en, w_fin_in, r_en;
  byte_t            w_data, q;
  logic             we, re, w_open, r_busy, r_left, r_short, zlp_pend;
  logic [AW-1:0]    waddr, raddr;

  assign dir      = cfg_dir_in ? DIR_IN : DIR_OUT;
  assign w_en     = (dir == DIR_IN) ? cpu_wr_en   : sie_wr_en;
  assign w_data   = (dir == DIR_IN) ? cpu_wr_data : sie_wr_data;
  assign w_fin_in = (dir == DIR_IN) ? cpu_commit  : sie_rx_done;
  assign r_en     = (dir == DIR_IN) ? sie_rd_en   : cpu_rd_en;

  epbuf_cfg #(
    .MAX_BYTES(MAX_BYTES), .UNIT_BYTES(UNIT_BYTES), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
  ) i_cfg (
    .clk(clk), .rst(rst), .dir_in(cfg_dir_in), .dbl(cfg_dbl),
    .size(cfg_size), .mps(cfg_mps), .lim(lim), .cfg_bad(cfg_bad)
  );

  epbuf_own #(.PTR_W(PTR_W), .CNT_W(CNT_W)) i_own (
    .clk(clk), .rst(rst), .dbl(cfg_dbl), .dir_in(cfg_dir_in), .zlp_en(cfg_zlp_en),
    .lim(lim), .mps(cfg_mps), .w_en(w_en), .w_fin_in(w_fin_in), .r_en(r_en),
    .r_done_in(sie_tx_done), .we(we), .waddr(waddr), .re(re), .raddr(raddr),
    .w_open(w_open), .w_cnt_o(w_cnt), .r_busy_o(r_busy), .r_left_o(r_left),
    .r_cnt_o(r_cnt), .r_short_o(r_short), .zlp_pend_o(zlp_pend)
  );

  epbuf_ram #(.DEPTH(DEPTH), .AW(AW), .DW(BYTE_W)) i_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(w_data),
    .re(re), .raddr(raddr), .rdata(q)
  );

  assign sie_rd_data  = q;
  assign cpu_rd_data  = q;
  assign sie_rx_ok    = (dir == DIR_OUT) && w_open;
  assign sie_tx_avail = (dir == DIR_IN) && r_busy;
  assign sie_tx_len   = (dir == DIR_IN) ? r_cnt : '0;
  assign sie_tx_zlp   = zlp_pend;
  assign cpu_ready    = (dir == DIR_IN) ? (w_open && (w_cnt == '0)) : r_left;
  assign cpu_len      = (dir == DIR_IN) ? w_cnt : r_cnt;
  assign cpu_short    = (dir == DIR_OUT) && r_short;
endmodule

// File: tb/test_epbuf_pingpong.sv
`timescale 1ns/1ps
module test_epbuf_pingpong;
  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_dir_in = 1'b0, cfg_dbl = 1'b0, cfg_zlp_en = 1'b0;
  logic [3:0]  cfg_size = 4'd0;
  logic [10:0] cfg_mps = 11'd64;
  logic        sie_wr_en = 0, sie_rx_done = 0, sie_rd_en = 0, sie_tx_done = 0;
  logic [7:0]  sie_wr_data = 0, cpu_wr_data = 0;
  logic        cpu_wr_en = 0, cpu_commit = 0, cpu_rd_en = 0;
  logic        sie_rx_ok, sie_tx_avail, sie_tx_zlp, cpu_ready, cpu_short, cfg_bad;
  logic [7:0]  sie_rd_data, cpu_rd_data;
  logic [10:0] sie_tx_len, cpu_len;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  // {dir_in, dbl, size, mps, expected cfg_bad}
  localparam logic [17:0] VEC [8] = '{
    {1'b1, 1'b1, 4'd0,  11'd64,   1'b1},
    {1'b1, 1'b1, 4'd1,  11'd64,   1'b0},
    {1'b1, 1'b0, 4'd0,  11'd64,   1'b0},
    {1'b1, 1'b0, 4'd0,  11'd65,   1'b1},
    {1'b0, 1'b1, 4'd0,  11'd64,   1'b0},
    {1'b1, 1'b0, 4'd15, 11'd1023, 1'b0},
    {1'b1, 1'b1, 4'd15, 11'd1024, 1'b1},
    {1'b1, 1'b0, 4'd15, 11'd1024, 1'b0}
  };

  always #2 clk = ~clk;

  epbuf_pingpong i_epbuf_pingpong (
    .clk(clk), .rst(rst), .cfg_dir_in(cfg_dir_in), .cfg_dbl(cfg_dbl),
    .cfg_size(cfg_size), .cfg_mps(cfg_mps), .cfg_zlp_en(cfg_zlp_en),
    .sie_wr_en(sie_wr_en), .sie_wr_data(sie_wr_data), .sie_rx_done(sie_rx_done),
    .sie_rx_ok(sie_rx_ok), .sie_rd_en(sie_rd_en), .sie_rd_data(sie_rd_data),
    .sie_tx_done(sie_tx_done), .sie_tx_avail(sie_tx_avail), .sie_tx_len(sie_tx_len),
    .sie_tx_zlp(sie_tx_zlp), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .cpu_commit(cpu_commit), .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
    .cpu_ready(cpu_ready), .cpu_len(cpu_len), .cpu_short(cpu_short), .cfg_bad(cfg_bad)
  );

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic idle(input int n); repeat (n) tick(); endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(input logic d, input logic b, input logic [3:0] s,
                         input logic [10:0] m, input logic z);
    cfg_dir_in = d; cfg_dbl = b; cfg_size = s; cfg_mps = m; cfg_zlp_en = z;
    rst = 1'b1; idle(2); rst = 1'b0; idle(1);
  endtask

  task automatic sie_put(input logic [7:0] v);
    sie_wr_en = 1; sie_wr_data = v; tick(); sie_wr_en = 0;
  endtask
  task automatic cpu_put(input logic [7:0] v);
    cpu_wr_en = 1; cpu_wr_data = v; tick(); cpu_wr_en = 0;
  endtask
  task automatic rx_end(); sie_rx_done = 1; tick(); sie_rx_done = 0; idle(3); endtask
  task automatic commit(); cpu_commit = 1; tick(); cpu_commit = 0; idle(3); endtask
  task automatic tx_end(); sie_tx_done = 1; tick(); sie_tx_done = 0; idle(3); endtask
  task automatic cpu_get(input string req, input int exp);
    cpu_rd_en = 1; tick(); cpu_rd_en = 0; chk(req, cpu_rd_data, exp);
  endtask
  task automatic sie_get(input string req, input int exp);
    sie_rd_en = 1; tick(); sie_rd_en = 0; chk(req, sie_rd_data, exp);
  endtask

  initial begin
    // OUT, single, 64-byte buffer, mps 64
    restart(1'b0, 1'b0, 4'd0, 11'd64, 1'b0);
    chk("R11 out cpu_ready", cpu_ready, 0);
    chk("R11 out sie_rx_ok", sie_rx_ok, 1);
    chk("R11 sie_tx_avail", sie_tx_avail, 0);
    chk("R11 cpu_len", cpu_len, 0);
    for (int i = 0; i < 5; i++) sie_put(8'h10 + 8'(i));
    rx_end();
    chk("R2 cpu_ready", cpu_ready, 1);
    chk("R2 cpu_len", cpu_len, 5);
    chk("R8 short packet", cpu_short, 1);
    chk("R4 sie_rx_ok while cpu owns", sie_rx_ok, 0);
    sie_put(8'hEE);
    sie_rx_done = 1; tick(); sie_rx_done = 0; idle(2);
    chk("R4 write ignored, cpu_len", cpu_len, 5);
    for (int i = 0; i < 5; i++) cpu_get("R2 out byte", 'h10 + i);
    idle(3);
    chk("R2 drained cpu_ready", cpu_ready, 0);
    chk("R2 drained sie_rx_ok", sie_rx_ok, 1);
    for (int i = 0; i < 70; i++) sie_put(8'(i));
    rx_end();
    chk("R1 count capped", cpu_len, 64);
    chk("R8 full packet", cpu_short, 0);
    for (int i = 0; i < 64; i++) cpu_get("R1 capped byte", i);

    // OUT, double
    restart(1'b0, 1'b1, 4'd0, 11'd64, 1'b0);
    for (int i = 0; i < 3; i++) sie_put(8'h20 + 8'(i));
    rx_end();
    chk("R3 first cpu_len", cpu_len, 3);
    chk("R3 sie_rx_ok double", sie_rx_ok, 1);
    for (int i = 0; i < 4; i++) sie_put(8'h30 + 8'(i));
    rx_end();
    chk("R3 no swap before drain", cpu_len, 3);
    chk("R3 sie waits", sie_rx_ok, 0);
    for (int i = 0; i < 3; i++) cpu_get("R3 first packet byte", 'h20 + i);
    idle(3);
    chk("R3 swapped cpu_len", cpu_len, 4);
    chk("R3 swapped cpu_ready", cpu_ready, 1);
    for (int i = 0; i < 4; i++) cpu_get("R3 second packet byte", 'h30 + i);

    // IN, double, 128 bytes, mps 4, zero-length packet enabled
    restart(1'b1, 1'b1, 4'd1, 11'd4, 1'b1);
    chk("R11 in cpu_ready", cpu_ready, 1);
    chk("R11 sie_tx_zlp", sie_tx_zlp, 0);
    for (int i = 0; i < 3; i++) cpu_put(8'h40 + 8'(i));
    commit();
    chk("R5 sie_tx_avail", sie_tx_avail, 1);
    chk("R5 sie_tx_len", sie_tx_len, 3);
    chk("R7 no zlp for short", sie_tx_zlp, 0);
    chk("R6 cpu_ready other half", cpu_ready, 1);
    for (int i = 0; i < 3; i++) sie_get("R5 in byte", 'h40 + i);
    sie_get("R10 read past count holds", 'h42);
    for (int i = 0; i < 8; i++) cpu_put(8'h50 + 8'(i));
    commit();
    chk("R6 no swap before tx_done", sie_tx_len, 3);
    chk("R6 cpu waits", cpu_ready, 0);
    tx_end();
    chk("R6 swapped avail", sie_tx_avail, 1);
    chk("R6 swapped len", sie_tx_len, 8);
    chk("R6 cpu_ready after swap", cpu_ready, 1);
    sie_get("R6 second packet byte", 'h50);
    tx_end();
    chk("R7 zlp owed", sie_tx_zlp, 1);
    chk("R7 no data offered", sie_tx_avail, 0);
    for (int i = 0; i < 2; i++) cpu_put(8'h60 + 8'(i));
    commit();
    chk("R7 held behind zlp", sie_tx_avail, 0);
    tx_end();
    chk("R7 zlp cleared", sie_tx_zlp, 0);
    chk("R7 next offered", sie_tx_avail, 1);
    chk("R7 next len", sie_tx_len, 2);

    // IN, single, mps 4, zero-length packet disabled
    restart(1'b1, 1'b0, 4'd0, 11'd4, 1'b0);
    for (int i = 0; i < 4; i++) cpu_put(8'h70 + 8'(i));
    commit();
    chk("R5 single avail", sie_tx_avail, 1);
    chk("R4 cpu_ready while sie owns", cpu_ready, 0);
    cpu_put(8'hAA);
    cpu_commit = 1; tick(); cpu_commit = 0; idle(2);
    for (int i = 0; i < 4; i++) sie_get("R5 single byte", 'h70 + i);
    tx_end();
    chk("R7 disabled no zlp", sie_tx_zlp, 0);
    chk("R4 ignored commit", sie_tx_avail, 0);
    chk("R4 ignored write", cpu_len, 0);
    chk("R4 cpu_ready back", cpu_ready, 1);

    // configuration legality table
    restart(1'b0, 1'b0, 4'd0, 11'd64, 1'b0);
    for (int i = 0; i < 8; i++) begin
      cfg_dir_in = VEC[i][17]; cfg_dbl = VEC[i][16];
      cfg_size = VEC[i][15:12]; cfg_mps = VEC[i][11:1];
      idle(2);
      chk("R9 cfg_bad", cfg_bad, int'(VEC[i][0]));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all R actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule